// File: doc/BRIEF.md
# Variable-Resolution Tracking Position Counter

This block is the digital half of a tracking angle converter. An external loop (demodulator, integrator and voltage-controlled oscillator, all outside this block) emits one step pulse for each least-significant increment of angle, plus a level that gives the sense of rotation. The block turns those pulses into a 16-bit natural-binary angle word. The resolution is picked at run time from 10, 12, 14 or 16 bits. At the coarser settings the live bits sit at the top of the word and the spare low bits read as zero.

Each applied step raises a busy strobe for a fixed number of clock cycles, during which the word must be treated as unsettled. A direction flag shows the sense of the latest count. A wrap flag marks every pass through zero or full scale, which external logic can use to count whole turns. A parallel preload from the data bus, active low, overrides counting. Steps that arrive while busy is high are held, one deep, and applied as soon as the strobe ends.

Top module: `trk_pos_counter`

## Requirements
- R1: After reset, pos_o is 0, busy_o is 0, wrap_o is 0 and dir_o is 1.
- R2: res_sel_i picks the resolution as 00 = 10 bits, 01 = 12 bits, 10 = 14 bits, 11 = 16 bits. An applied step adds (up_i = 1) or subtracts (up_i = 0) one LSB of that resolution, which is 64, 16, 4 or 1 in the 16-bit word, modulo the live range. The new value shows on pos_o one cycle after the clock edge that samples the step.
- R3: dir_o takes the direction of each applied step on the same edge as the position update: 1 for up, 0 for down. It changes at no other time.
- R4: The bits of pos_o below the selected LSB are always zero. When res_sel_i changes, those low bits clear on the next edge and the upper bits are kept.
- R5: A step is applied only when busy_o is low. busy_o then stays high for exactly BUSY_CYC cycles, starting with the cycle in which the new position appears.
- R6: wrap_o is high for the whole busy period of an update that goes from all live ones to zero while counting up, or from zero to all live ones while counting down. Otherwise it is low.
- R7: While load_n_i is low, the next edge loads load_data_i with its bits below the selected LSB cleared.
- R8: A load takes priority. A step sampled while load_n_i is low is dropped and does not start busy_o. A load also discards any held step.
- R9: A step sampled while busy_o is high is held and applied on the first edge at which busy_o is low. If several steps arrive during one busy period, only the direction of the last one is used, and it is applied as a single step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | One-cycle increment pulse from the oscillator |
| up_i | input | 1 | Count sense sampled with step_i: 1 = up, 0 = down |
| res_sel_i | input | 2 | Resolution select (see R2) |
| load_n_i | input | 1 | Parallel preload, active low |
| load_data_i | input | 16 | Preload value from the data bus |
| pos_o | output | 16 | Angle word, live bits left-aligned |
| busy_o | output | 1 | High while the word is settling after a step |
| dir_o | output | 1 | Sense of the latest applied step |
| wrap_o | output | 1 | High for the busy period of a zero/full-scale crossing |

## Verification
A corrupted position register shows up at pos_o one cycle after the step, load or select change that exposes it, because every update is visible without delay. A broken busy timer shows up as a strobe of the wrong length, or as a held step that is applied too early, too late or twice; this is seen by the first busy edge after the fault. A bad wrap detector or a wrong shift in the LSB decode shows up at the first step taken at the affected resolution or the affected end of scale. For that reason, every resolution and both wrap directions are stepped through.

// File: rtl/trk_pos_pkg.sv
package trk_pos_pkg;

  localparam int POS_W    = 16;
  localparam int NUM_RES  = 4;
  localparam int MIN_BITS = 10;
  localparam int RES_STEP = 2;
  localparam int SEL_W    = $clog2(NUM_RES);

  typedef logic [POS_W-1:0] pos_t;
  typedef logic [SEL_W-1:0] sel_t;

  // number of live bits for a select code
  function automatic int live_bits(input sel_t sel);
    return MIN_BITS + RES_STEP * int'(sel);
  endfunction

  // weight of one step in the left-aligned word
  function automatic pos_t lsb_weight(input sel_t sel);
    pos_t w;
    w = '0;
    w[POS_W - live_bits(sel)] = 1'b1;
    return w;
  endfunction

  // ones over the live bits, zeros below
  function automatic pos_t live_mask(input sel_t sel);
    return ~(lsb_weight(sel) - pos_t'(1));
  endfunction

  function automatic pos_t stepped(input pos_t cur, input pos_t lsb,
                                   input pos_t mask, input logic up);
    pos_t base;
    base = cur & mask;
    return up ? ((base + lsb) & mask) : ((base - lsb) & mask);
  endfunction

  function automatic logic crosses_end(input pos_t cur, input pos_t mask,
                                       input logic up);
    return up ? ((cur & mask) == mask) : ((cur & mask) == '0);
  endfunction

endpackage

// File: rtl/trk_res_decode.sv
module trk_res_decode
  import trk_pos_pkg::*;
(
  input  sel_t sel_i,
  output pos_t mask_o,
  output pos_t lsb_o
);

  pos_t mask_tbl [NUM_RES];
  pos_t lsb_tbl  [NUM_RES];

  for (genvar g = 0; g < NUM_RES; g++) begin : g_mode
    assign mask_tbl[g] = live_mask(sel_t'(g));
    assign lsb_tbl[g]  = lsb_weight(sel_t'(g));
  end

  assign mask_o = mask_tbl[sel_i];
  assign lsb_o  = lsb_tbl[sel_i];

endmodule

// File: rtl/trk_step_gate.sv
module trk_step_gate #(
  parameter int BUSY_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  input  logic up_i,
  input  logic load_n_i,
  input  logic wrap_now_i,
  output logic apply_o,
  output logic apply_up_o,
  output logic busy_o,
  output logic dir_o,
  output logic wrap_o
);

  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  logic [CNT_W-1:0] busy_cnt;
  logic             pend_q;
  logic             pend_up_q;
  logic             dir_q;
  logic             wrap_q;
  logic             busy_w;

  assign busy_w     = (busy_cnt != '0);
  assign apply_o    = load_n_i && !busy_w && (step_i || pend_q);
  assign apply_up_o = pend_q ? pend_up_q : up_i;

  // held-step register: one deep, newest direction wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      pend_up_q <= 1'b1;
    end else if (!load_n_i) begin
      pend_q    <= 1'b0;
    end else if (apply_o) begin
      pend_q    <= pend_q && step_i;
      pend_up_q <= up_i;
    end else if (step_i) begin
      pend_q    <= 1'b1;
      pend_up_q <= up_i;
    end
  end

  // busy timer and per-update flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      dir_q    <= 1'b1;
      wrap_q   <= 1'b0;
    end else if (apply_o) begin
      busy_cnt <= CNT_W'(BUSY_CYC);
      dir_q    <= apply_up_o;
      wrap_q   <= wrap_now_i;
    end else if (busy_w) begin
      busy_cnt <= busy_cnt - 1'b1;
    end
  end

  assign busy_o = busy_w;
  assign dir_o  = dir_q;
  assign wrap_o = wrap_q && busy_w;

  // run-length counter for the busy width check
  logic [CNT_W:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_len <= '0;
    else if (busy_w) run_len <= run_len + 1'b1;
    else             run_len <= '0;
  end

  assert_busy_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_len == (CNT_W+1)'(BUSY_CYC)));

  assert_wrap_starts_with_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrap_o) |-> $rose(busy_o));

  assert_dir_moves_on_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_o != $past(dir_o)) |-> $rose(busy_o));

  assert_load_blocks_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n_i && !busy_o) |=> !busy_o);

endmodule

// File: rtl/trk_pos_acc.sv
module trk_pos_acc
  import trk_pos_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic apply_i,
  input  logic up_i,
  input  logic load_n_i,
  input  pos_t load_data_i,
  input  pos_t mask_i,
  input  pos_t lsb_i,
  output pos_t pos_o,
  output logic wrap_now_o
);

  pos_t pos_q;
  pos_t pos_next;

  always_comb begin
    if (!load_n_i)    pos_next = load_data_i & mask_i;
    else if (apply_i) pos_next = stepped(pos_q, lsb_i, mask_i, up_i);
    else              pos_next = pos_q & mask_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_next;
  end

  assign wrap_now_o = apply_i && crosses_end(pos_q, mask_i, up_i);
  assign pos_o      = pos_q;

  assert_low_bits_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pos_q & ~$past(mask_i)) == '0));

  assert_load_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n_i |=> (pos_q == ($past(load_data_i) & $past(mask_i))));

endmodule

// File: rtl/trk_pos_counter.sv
module trk_pos_counter
  import trk_pos_pkg::*;
#(
  parameter int BUSY_CYC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             up_i,
  input  logic [1:0]       res_sel_i,
  input  logic             load_n_i,
  input  logic [15:0]      load_data_i,
  output logic [15:0]      pos_o,
  output logic             busy_o,
  output logic             dir_o,
  output logic             wrap_o
);

  pos_t mask_w;
  pos_t lsb_w;
  logic apply_w;
  logic apply_up_w;
  logic wrap_now_w;

  trk_res_decode u_dec (
    .sel_i  (res_sel_i),
    .mask_o (mask_w),
    .lsb_o  (lsb_w)
  );

  trk_step_gate #(.BUSY_CYC(BUSY_CYC)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (step_i),
    .up_i       (up_i),
    .load_n_i   (load_n_i),
    .wrap_now_i (wrap_now_w),
    .apply_o    (apply_w),
    .apply_up_o (apply_up_w),
    .busy_o     (busy_o),
    .dir_o      (dir_o),
    .wrap_o     (wrap_o)
  );

  trk_pos_acc u_acc (
    .clk         (clk),
    .rst_n       (rst_n),
    .apply_i     (apply_w),
    .up_i        (apply_up_w),
    .load_n_i    (load_n_i),
    .load_data_i (load_data_i),
    .mask_i      (mask_w),
    .lsb_i       (lsb_w),
    .pos_o       (pos_o),
    .wrap_now_o  (wrap_now_w)
  );

  // no count movement inside a busy period
  assert_hold_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && $past(load_n_i)
     && ($past(res_sel_i) == $past(res_sel_i, 2))) |-> $stable(pos_o));

endmodule

// File: tb/trk_pos_counter_test.sv
module trk_pos_counter_test;

  localparam int BUSY = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_i = 1'b0;
  logic        up_i = 1'b1;
  logic [1:0]  res_sel_i = 2'b11;
  logic        load_n_i = 1'b1;
  logic [15:0] load_data_i = '0;
  logic [15:0] pos_o;
  logic        busy_o, dir_o, wrap_o;

  always #2 clk = ~clk;

  trk_pos_counter #(.BUSY_CYC(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .up_i(up_i),
    .res_sel_i(res_sel_i), .load_n_i(load_n_i), .load_data_i(load_data_i),
    .pos_o(pos_o), .busy_o(busy_o), .dir_o(dir_o), .wrap_o(wrap_o)
  );

  typedef struct {
    logic [15:0] pos;
    logic        wrap;
    logic        dir;
    string       req;
  } exp_t;

  exp_t        exp_q[$];
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;
  logic [15:0] model_pos = '0;

  function automatic int drop_bits(input logic [1:0] s);
    return 16 - (10 + 2 * int'(s));
  endfunction

  function automatic logic [15:0] top_mask(input logic [1:0] s);
    return 16'hFFFF << drop_bits(s);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compare each new update against the queue
  logic prev_busy = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_o && !prev_busy) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R9 unexpected update actual=%0h expected=none", pos_o);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({e.req, " pos"}, 32'(pos_o), 32'(e.pos));
          check("R6 wrap", 32'(wrap_o), 32'(e.wrap));
          check("R3 dir", 32'(dir_o), 32'(e.dir));
        end
      end
      prev_busy <= busy_o;
    end
  end

  // predicts one step from the bench's own model
  function automatic exp_t predict(input logic up, input string req);
    exp_t e;
    logic [15:0] m;
    logic [16:0] wide;
    m = top_mask(res_sel_i);
    if (up) begin
      wide   = {1'b0, model_pos} + (17'd1 << drop_bits(res_sel_i));
      e.wrap = wide[16];
    end else begin
      e.wrap = (model_pos == 16'd0);
      wide   = {1'b0, model_pos} - (17'd1 << drop_bits(res_sel_i));
    end
    model_pos = wide[15:0] & m;
    e.pos = model_pos;
    e.dir = up;
    e.req = req;
    return e;
  endfunction

  task automatic wait_idle(input bit measure, input string req);
    int width = 0;
    while (busy_o) begin
      width++;
      @(negedge clk);
    end
    if (measure) check(req, 32'(width), 32'(BUSY));
  endtask

  task automatic do_step(input logic up, input string req);
    @(negedge clk);
    step_i = 1'b1; up_i = up;
    exp_q.push_back(predict(up, req));
    @(negedge clk);
    step_i = 1'b0;
    wait_idle(1'b1, "R5 busy width");
  endtask

  task automatic do_load(input logic [15:0] d, input logic with_step);
    @(negedge clk);
    load_n_i = 1'b0; load_data_i = d; step_i = with_step;
    @(negedge clk);
    load_n_i = 1'b1; step_i = 1'b0;
    model_pos = d & top_mask(res_sel_i);
    check("R7 load value", 32'(pos_o), 32'(model_pos));
  endtask

  task automatic do_sel(input logic [1:0] s);
    @(negedge clk);
    res_sel_i = s;
    @(negedge clk);
    model_pos = model_pos & top_mask(s);
    check("R4 select clears low bits", 32'(pos_o), 32'(model_pos));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pos", 32'(pos_o), 32'h0);
    check("R1 busy", 32'(busy_o), 32'h0);
    check("R1 wrap", 32'(wrap_o), 32'h0);
    check("R1 dir", 32'(dir_o), 32'h1);

    // R2 across all four resolutions
    do_load(16'h1235, 1'b0);
    do_step(1'b1, "R2 16-bit up");
    do_step(1'b0, "R2 16-bit down");
    do_sel(2'b01);
    do_step(1'b1, "R2 12-bit up");
    do_sel(2'b10);
    do_step(1'b0, "R2 14-bit down");
    do_sel(2'b00);
    do_step(1'b1, "R2 10-bit up");

    // R6 wraps at coarse and fine resolution
    do_load(16'hFFFF, 1'b0);
    do_step(1'b1, "R6 10-bit up wrap");
    do_step(1'b0, "R6 10-bit down wrap");
    do_sel(2'b11);
    do_load(16'hFFFF, 1'b0);
    do_step(1'b1, "R6 16-bit up wrap");
    do_step(1'b0, "R6 16-bit down wrap");
    do_step(1'b0, "R6 no wrap");

    // R8: step during load is dropped
    do_load(16'h4000, 1'b1);
    repeat (2) @(negedge clk);
    check("R8 no busy after step under load", 32'(busy_o), 32'h0);
    check("R8 pos unchanged", 32'(pos_o), 32'h4000);

    // R9: held step, newest direction wins, applied once
    @(negedge clk);
    step_i = 1'b1; up_i = 1'b1;
    exp_q.push_back(predict(1'b1, "R9 first"));
    @(negedge clk);
    step_i = 1'b1; up_i = 1'b1;
    @(negedge clk);
    step_i = 1'b1; up_i = 1'b0;
    @(negedge clk);
    step_i = 1'b0;
    exp_q.push_back(predict(1'b0, "R9 held step"));
    wait_idle(1'b0, "");
    @(negedge clk);
    check("R9 held step starts busy", 32'(busy_o), 32'h1);
    wait_idle(1'b1, "R5 busy width after held step");
    repeat (BUSY + 2) @(negedge clk);
    check("R9 single apply", 32'(busy_o), 32'h0);

    // R8: load discards a held step
    @(negedge clk);
    step_i = 1'b1; up_i = 1'b1;
    exp_q.push_back(predict(1'b1, "R8 step before load"));
    @(negedge clk);
    step_i = 1'b1; up_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0; load_n_i = 1'b0; load_data_i = 16'h0777;
    @(negedge clk);
    load_n_i = 1'b1;
    check("R8 load during busy", 32'(pos_o), 32'h0777);
    wait_idle(1'b0, "");
    repeat (BUSY + 2) @(negedge clk);
    check("R8 held step discarded busy", 32'(busy_o), 32'h0);
    check("R8 held step discarded pos", 32'(pos_o), 32'h0777);

    check("R2 scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule